// File: doc/BRIEF.md
# LCD Frame and Common-Phase Clock Generator

This block produces the timing for a multiplexed segment display. It picks one of three time bases: the fast system clock through a fixed divider, a 32 kHz crystal tick, or a 31 kHz internal tick. It divides that time base with a programmable prescaler and a fixed halving stage to make a one-cycle segment-clock enable. A final divider, set by the multiplex mode, advances a ring of common-line strobes. Only one common line is driven at a time, and the ring holds as many phases as the multiplex mode calls for.

Everything runs on the system clock. The two slow sources arrive as single-cycle tick enables that are already synchronised to that clock. A sleep input stops the system-clock path only. When a slow source is selected, frame timing carries on while sleep is asserted. When any configuration field changes, the whole chain restarts from a clean state, so a partial period never appears at the outputs. The block has no data stream: all pins are plain control and timing levels or pulses, and there is no back-pressure.

Top module: `lcd_frame_clkgen`

## Requirements
- R1: The source select `src_sel_i` decodes as follows: 0 selects the system-clock path, 1 selects the crystal tick, and both 2 and 3 select the internal low-frequency tick.
- R2: With the system-clock source, one base tick occurs every SYS_DIV clock cycles (default 256). This ratio is fixed.
- R3: With a slow source, one base tick occurs every LS_DIV ticks of that source (default 32).
- R4: A prescale field value N divides the base ticks by N+1, for N from 0 to 15. The prescaler count cannot be observed or loaded.
- R5: `seg_clk_en_o` is a pulse one cycle wide. It is raised one clock after every second prescaler output, and it is never high for two cycles in a row.
- R6: `com_o` bit i drives common line i. The active phase advances once every (mode+1) segment-clock pulses, on the same clock edge that raises `seg_clk_en_o`.
- R7: The multiplex mode m (0 = static, 1 = 1/2, 2 = 1/3, 3 = 1/4) cycles the phases 0,1,..,m,0 in that order. At most one bit of `com_o` is high, and bits above m are never high.
- R8: On the clock after any of `src_sel_i`, `presc_i` or `mux_mode_i` differs from its stored value, every divider count and the phase are cleared to COM0. A tick that arrives in that cycle is ignored, and no segment pulse follows it.
- R9: While `sleep_i` is high with a slow source selected, counting continues as when awake, and exactly one `com_o` bit stays high.
- R10: While `sleep_i` is high with the system-clock source selected, all counts hold, `com_o` is all zero and no segment pulse is issued. Counting resumes from the held state after wake-up.
- R11: During and right after reset, `com_o` = 4'b0001 (COM0) and `seg_clk_en_o` = 0. After reset, the stored configuration is source 0, prescale 0, mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_i | input | 1 | Sleep request; halts only the system-clock path |
| xtal_tick_i | input | 1 | One-cycle tick from the 32 kHz crystal time base |
| lfi_tick_i | input | 1 | One-cycle tick from the 31 kHz internal time base |
| src_sel_i | input | 2 | Source select (see R1) |
| presc_i | input | PRE_W (4) | Prescale field, ratio = value + 1 |
| mux_mode_i | input | MODE_W (2) | Multiplex mode: number of common phases minus one |
| seg_clk_en_o | output | 1 | Segment-clock enable pulse |
| com_o | output | N_COM (4) | One-hot common-line strobes, bit i is COMi |

## Verification
The bench targets the restart on a configuration change. A design that kept its old counts would emit a short first period, or would leave the ring on a phase beyond the new mode and drive a common line that does not exist in that mode. It also checks the alias of select code 3 against code 2. A wrong decode would drift away from the internal tick rate or stop altogether. The sleep split is exercised both ways. A design that froze the slow sources would lose its segment pulses, and one that kept the system path running would drive strobes or lose its held phase. The extreme prescale values 0 and 15 are checked, and so are the static mode and full four-phase mode, where an off-by-one in a wrap compare changes the measured pulse spacing.

// File: rtl/lcd_fc_pkg.sv
package lcd_fc_pkg;

  typedef enum logic [1:0] {
    SRC_SYS     = 2'd0,
    SRC_XTAL    = 2'd1,
    SRC_LFI     = 2'd2,
    SRC_LFI_ALT = 2'd3
  } src_e;

  // True when the source keeps running while the core sleeps
  function automatic logic src_is_slow(input src_e s);
    return (s != SRC_SYS);
  endfunction

endpackage

// File: rtl/lcd_fc_src.sv
// Source selection and fixed pre-division: one base tick out.
module lcd_fc_src
  import lcd_fc_pkg::*;
#(
  parameter int SYS_DIV = 256,
  parameter int LS_DIV  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  src_e src,
  input  logic xtal_tick,
  input  logic lfi_tick,
  output logic base_tick
);

  localparam int SW = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;
  localparam int LW = (LS_DIV > 2) ? $clog2(LS_DIV) : 1;
  localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
  localparam logic [LW-1:0] LS_LAST  = LW'(LS_DIV - 1);

  logic [SW-1:0] sys_cnt;
  logic [LW-1:0] ls_cnt;
  logic          slow_tick;
  logic          sys_wrap;
  logic          ls_wrap;

  always_comb begin
    unique case (src)
      SRC_XTAL:    slow_tick = xtal_tick;
      SRC_LFI,
      SRC_LFI_ALT: slow_tick = lfi_tick;
      default:     slow_tick = 1'b0;
    endcase
  end

  assign sys_wrap  = (sys_cnt == SYS_LAST);
  assign ls_wrap   = (ls_cnt == LS_LAST);
  assign base_tick = run && (src_is_slow(src) ? (slow_tick && ls_wrap) : sys_wrap);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sys_cnt <= '0;
    end else if (run && !src_is_slow(src)) begin
      sys_cnt <= sys_wrap ? '0 : sys_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ls_cnt <= '0;
    end else if (run && src_is_slow(src) && slow_tick) begin
      ls_cnt <= ls_wrap ? '0 : ls_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_fc_div.sv
// Programmable modulus divider on an enable stream: ratio = limit + 1.
module lcd_fc_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_i,
  input  logic [W-1:0] limit,
  output logic         tick_o
);

  logic [W-1:0] cnt;
  logic         at_last;

  assign at_last = (cnt == limit);
  assign tick_o  = tick_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_fc_ring.sv
// Common-phase ring: steps 0..last and wraps; outputs one-hot strobes.
module lcd_fc_ring #(
  parameter int N_COM  = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [MODE_W-1:0] last,
  input  logic              halt,
  output logic [N_COM-1:0]  com
);

  logic [MODE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase <= '0;
    end else if (step) begin
      phase <= (phase == last) ? '0 : phase + 1'b1;
    end
  end

  for (genvar g = 0; g < N_COM; g++) begin : g_com
    assign com[g] = !halt && (phase == MODE_W'(g));
  end

endmodule

// File: rtl/lcd_frame_clkgen.sv
module lcd_frame_clkgen
  import lcd_fc_pkg::*;
#(
  parameter int SYS_DIV = 256,
  parameter int LS_DIV  = 32,
  parameter int PRE_W   = 4,
  parameter int N_COM   = 4,
  localparam int MODE_W = (N_COM > 2) ? $clog2(N_COM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              xtal_tick_i,
  input  logic              lfi_tick_i,
  input  logic [1:0]        src_sel_i,
  input  logic [PRE_W-1:0]  presc_i,
  input  logic [MODE_W-1:0] mux_mode_i,
  output logic              seg_clk_en_o,
  output logic [N_COM-1:0]  com_o
);

  src_e              src_q;
  logic [PRE_W-1:0]  presc_q;
  logic [MODE_W-1:0] mode_q;
  logic              cfg_chg;
  logic              halt;
  logic              run;
  logic              base_tick;
  logic              pre_tick;
  logic              half_tick;
  logic              com_step;
  logic              seg_q;

  assign cfg_chg = (src_q != src_e'(src_sel_i)) || (presc_q != presc_i) ||
                   (mode_q != mux_mode_i);
  assign halt    = sleep_i && !src_is_slow(src_q);
  assign run     = !halt && !cfg_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= SRC_SYS;
      presc_q <= '0;
      mode_q  <= '0;
    end else if (cfg_chg) begin
      src_q   <= src_e'(src_sel_i);
      presc_q <= presc_i;
      mode_q  <= mux_mode_i;
    end
  end

  lcd_fc_src #(.SYS_DIV(SYS_DIV), .LS_DIV(LS_DIV)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_chg),
    .run       (run),
    .src       (src_q),
    .xtal_tick (xtal_tick_i),
    .lfi_tick  (lfi_tick_i),
    .base_tick (base_tick)
  );

  lcd_fc_div #(.W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_chg),
    .tick_i (base_tick),
    .limit  (presc_q),
    .tick_o (pre_tick)
  );

  lcd_fc_div #(.W(1)) u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_chg),
    .tick_i (pre_tick),
    .limit  (1'b1),
    .tick_o (half_tick)
  );

  lcd_fc_div #(.W(MODE_W)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_chg),
    .tick_i (half_tick),
    .limit  (mode_q),
    .tick_o (com_step)
  );

  lcd_fc_ring #(.N_COM(N_COM), .MODE_W(MODE_W)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_chg),
    .step  (com_step),
    .last  (mode_q),
    .halt  (halt),
    .com   (com_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_chg) begin
      seg_q <= 1'b0;
    end else begin
      seg_q <= half_tick;
    end
  end

  assign seg_clk_en_o = seg_q;

endmodule

// File: rtl/lcd_fc_chk.sv
module lcd_fc_chk #(
  parameter int PRE_W  = 4,
  parameter int N_COM  = 4,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic [1:0]        src_sel_i,
  input logic [PRE_W-1:0]  presc_i,
  input logic [MODE_W-1:0] mux_mode_i,
  input logic              seg_clk_en_o,
  input logic [N_COM-1:0]  com_o
);

  // R5: pulse is one cycle wide
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seg_clk_en_o |=> !seg_clk_en_o);

  // R7: never more than one common line
  a_r7_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_o) <= 1);

  // R7: lines beyond the multiplex count stay low
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mux_mode_i) == mux_mode_i) |->
      ((32'(com_o) >> (int'(mux_mode_i) + 1)) == 0));

  // R8: a configuration change restarts at COM0 with no pulse
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel_i != $past(src_sel_i)) || (presc_i != $past(presc_i)) ||
     (mux_mode_i != $past(mux_mode_i)))
    |=> ((com_o[N_COM-1:1] == '0) && !seg_clk_en_o));

  // R9: awake, or asleep on a slow source, exactly one line is driven
  a_r9_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i || ((src_sel_i != 2'd0) && ($past(src_sel_i) == src_sel_i)))
      |-> ($countones(com_o) == 1));

  // R10: system-clock path asleep is silent
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && $past(sleep_i) && (src_sel_i == 2'd0) && ($past(src_sel_i) == 2'd0))
      |-> ((com_o == '0) && !seg_clk_en_o));

  // R11: reset state
  always @(posedge clk) begin
    if (!rst_n) begin
      #1;
      a_r11_reset_com: assert (com_o == N_COM'(1) && !seg_clk_en_o);
    end
  end

endmodule

bind lcd_frame_clkgen lcd_fc_chk #(.PRE_W(PRE_W), .N_COM(N_COM), .MODE_W(MODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_i      (sleep_i),
  .src_sel_i    (src_sel_i),
  .presc_i      (presc_i),
  .mux_mode_i   (mux_mode_i),
  .seg_clk_en_o (seg_clk_en_o),
  .com_o        (com_o)
);

// File: tb/test_lcd_frame_clkgen.sv
module test_lcd_frame_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int SYS_DIV = 4;
  localparam int LS_DIV  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_i = 1'b0;
  logic       xtal_tick_i = 1'b0;
  logic       lfi_tick_i = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic [3:0] presc_i = 4'd0;
  logic [1:0] mux_mode_i = 2'd0;
  logic       seg_clk_en_o;
  logic [3:0] com_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_clkgen #(.SYS_DIV(SYS_DIV), .LS_DIV(LS_DIV)) i_lcd_frame_clkgen (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .xtal_tick_i(xtal_tick_i),
    .lfi_tick_i(lfi_tick_i), .src_sel_i(src_sel_i), .presc_i(presc_i),
    .mux_mode_i(mux_mode_i), .seg_clk_en_o(seg_clk_en_o), .com_o(com_o)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_sel, m_pre, m_mode, m_sys, m_ls, m_pc, m_half, m_mc, m_ph;
  bit m_seg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_pre = 0; m_mode = 0;
      m_sys = 0; m_ls = 0; m_pc = 0; m_half = 0; m_mc = 0; m_ph = 0; m_seg = 0;
    end else if (m_sel != int'(src_sel_i) || m_pre != int'(presc_i) || m_mode != int'(mux_mode_i)) begin
      m_sel = src_sel_i; m_pre = presc_i; m_mode = mux_mode_i;
      m_sys = 0; m_ls = 0; m_pc = 0; m_half = 0; m_mc = 0; m_ph = 0; m_seg = 0;
    end else if (sleep_i && m_sel == 0) begin
      m_seg = 0;
    end else begin
      bit base, slow;
      m_seg = 0;
      base = 0;
      if (m_sel == 0) begin
        m_sys = m_sys + 1;
        if (m_sys == SYS_DIV) begin m_sys = 0; base = 1; end
      end else begin
        slow = (m_sel == 1) ? xtal_tick_i : lfi_tick_i;
        if (slow) begin
          m_ls = m_ls + 1;
          if (m_ls == LS_DIV) begin m_ls = 0; base = 1; end
        end
      end
      if (base) begin
        m_pc = m_pc + 1;
        if (m_pc > m_pre) begin
          m_pc = 0;
          m_half = m_half + 1;
          if (m_half == 2) begin
            m_half = 0;
            m_seg = 1;
            m_mc = m_mc + 1;
            if (m_mc > m_mode) begin
              m_mc = 0;
              m_ph = (m_ph + 1) % (m_mode + 1);
            end
          end
        end
      end
    end
  end

  int cyc = 0;
  int last_seg = -1;
  int seg_gap = 0;
  int seg_count = 0;
  logic [3:0] prev_com = 4'd0;
  logic [3:0] com_seq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [3:0] exp_com;
    @(negedge clk);
    exp_com = (sleep_i && m_sel == 0) ? 4'd0 : 4'(1 << m_ph);
    if (rst_n) begin
      check(seg_clk_en_o === m_seg, "R5 seg pulse", int'(seg_clk_en_o), int'(m_seg));
      check(com_o === exp_com, "R6 R7 com strobes", int'(com_o), int'(exp_com));
      if (seg_clk_en_o) begin
        if (last_seg >= 0) seg_gap = cyc - last_seg;
        last_seg = cyc;
        seg_count++;
      end
      if (com_o != prev_com && com_o != 4'd0) com_seq.push_back(com_o);
      prev_com = com_o;
    end
    cyc++;
    xtal_tick_i = (cyc % 2 == 0);
    lfi_tick_i  = (cyc % 3 == 0);
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic configure(input int s, input int p, input int m);
    src_sel_i = 2'(s); presc_i = 4'(p); mux_mode_i = 2'(m);
    last_seg = -1; seg_gap = 0; seg_count = 0;
    com_seq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(com_o === 4'b0001, "R11 reset com", int'(com_o), 1);
    check(seg_clk_en_o === 1'b0, "R11 reset seg", int'(seg_clk_en_o), 0);
    rst_n = 1'b1;

    // R2 / R4: system path, prescale 0 then 15
    configure(0, 0, 3);
    run_n(200);
    check(seg_gap == 2 * SYS_DIV, "R2 sys gap presc0", seg_gap, 2 * SYS_DIV);
    configure(0, 15, 3);
    run_n(600);
    check(seg_gap == 2 * SYS_DIV * 16, "R4 sys gap presc15", seg_gap, 2 * SYS_DIV * 16);

    // R7: full four-phase order
    configure(0, 0, 3);
    run_n(400);
    check(com_seq.size() >= 5, "R7 phase count", com_seq.size(), 5);
    for (int i = 0; i + 1 < com_seq.size(); i++) begin
      logic [3:0] nx;
      nx = (com_seq[i] == 4'b1000) ? 4'b0001 : (com_seq[i] << 1);
      check(com_seq[i+1] == nx, "R7 phase order", int'(com_seq[i+1]), int'(nx));
    end

    // R3 / R1: crystal tick every 2 cycles, prescale 2
    configure(1, 2, 1);
    run_n(300);
    check(seg_gap == 2 * 2 * LS_DIV * 3, "R3 xtal gap", seg_gap, 2 * 2 * LS_DIV * 3);
    // R1: code 2 and code 3 both use the internal tick (every 3 cycles)
    configure(2, 1, 2);
    run_n(300);
    check(seg_gap == 3 * LS_DIV * 2 * 2, "R1 lfi gap sel2", seg_gap, 3 * LS_DIV * 2 * 2);
    configure(3, 1, 2);
    run_n(300);
    check(seg_gap == 3 * LS_DIV * 2 * 2, "R1 lfi gap sel3", seg_gap, 3 * LS_DIV * 2 * 2);
    check(!(com_seq.size() > 0 && com_seq[com_seq.size()-1] == 4'b1000), "R7 no COM3 in 1/3", 0, 0);

    // R7: static mode stays on COM0
    configure(0, 0, 0);
    run_n(120);
    check(com_o === 4'b0001, "R7 static COM0", int'(com_o), 1);

    // R8: change mid-period restarts (mode 3 -> 1 while on a high phase)
    configure(0, 0, 3);
    run_n(45);
    mux_mode_i = 2'd1;
    step();
    step();
    check(com_o === 4'b0001, "R8 restart to COM0", int'(com_o), 1);
    last_seg = -1; seg_gap = 0;
    run_n(100);

    // R9: sleep with a slow source keeps running
    configure(1, 0, 3);
    run_n(20);
    sleep_i = 1'b1;
    seg_count = 0;
    run_n(200);
    check(seg_count > 0, "R9 slow source sleeps awake", seg_count, 1);

    // R10: sleep with system source freezes
    sleep_i = 1'b0;
    configure(0, 0, 3);
    run_n(37);
    sleep_i = 1'b1;
    step();
    seg_count = 0;
    run_n(100);
    check(seg_count == 0, "R10 no pulse asleep", seg_count, 0);
    check(com_o === 4'b0000, "R10 strobes off", int'(com_o), 0);
    sleep_i = 1'b0;
    run_n(200);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule